// File: doc/BRIEF.md
# Receive Byte Pattern Matcher

This block watches the stream of bytes that a serial receiver hands on toward memory and compares each one against a small bank of programmable match slots. Each slot holds a candidate byte, an arm bit that enables it and a single-use bit. A byte that equals the candidate of an armed slot fires that slot. The slot then raises a one-cycle hit pulse and sets a sticky event flag. An interrupt line is asserted while any flag has its interrupt-enable bit set.

The arm bits change themselves as bytes arrive. A single-use slot disarms itself when it fires. A per-slot chain bit makes a hit on slot i arm slot i+1, and the last slot wraps round to slot 0. Loading the candidates and chain bits, then arming only the first slot, makes the event on the last slot in the chain mark a multi-byte sequence. Per-slot arm and disarm strobes give software or other blocks direct control.

Bytes arrive on a valid/ready stream. The block never stalls the stream while it is enabled: `byte_ready` equals `blk_en`. A byte counts only in a cycle where both `byte_valid` and `byte_ready` are high. A producer that holds `byte_valid` high while `blk_en` is low keeps its byte until the block is enabled.

Top module: `rxbyte_match`

## Requirements
- R1: Slot i fires on an accepted byte only when its arm bit is 1 and its candidate equals `byte_data`. Firing sets `hit[i]` for exactly the cycle after the byte is accepted.
- R2: When a slot fires and its single-use bit is 1, its arm bit reads 0 in the following cycle, unless a set source of R8 hits the same slot in that cycle.
- R3: `task_arm[i]` makes arm bit i read 1 in the next cycle. `task_disarm[i]` makes it read 0 in the next cycle, unless a set source of R8 is also active. Neither strobe changes any other slot.
- R4: When slot i fires and its chain bit is 1, arm bit (i+1) mod N reads 1 in the next cycle. A hit on slot N-1 arms slot 0.
- R5: A hit sets `evt_flag[i]`, and the flag stays set until it is cleared. `irq` equals the OR over all slots of `evt_flag[i] & irq_en[i]`.
- R6: `byte_ready` equals `blk_en`. A cycle with `byte_valid` low or `byte_ready` low produces no hit and changes no flag, whatever value `byte_data` holds.
- R7: When several armed slots hold the same candidate, all of them fire on one accepted byte in the same cycle.
- R8: There are two set sources for an arm bit: an arm strobe and a chain from the previous slot. There are two clear sources: a disarm strobe and a single-use hit. A whole-vector write by `arm_we` is the base value. Any set source beats any clear source, and either source beats the base value.
- R9: With `evt_we` high, every bit of `evt_wdata` that is 0 clears that event flag and every 1 bit leaves it. A hit in the same cycle still sets the flag. While `blk_en` is low, all flags and hits are held at 0.
- R10: `arm_we` loads `arm_wdata` into all arm bits (subject to R8). `cand_we` writes `cand_wdata` into the slot selected by `cand_idx`. `once_we` and `chain_we` load the single-use and chain vectors. Every write takes effect from the next cycle, and all registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| blk_en | input | 1 | Block enable; low holds the event flags at zero and refuses bytes |
| byte_valid | input | 1 | A received byte is offered |
| byte_ready | output | 1 | Byte accepted when high together with valid (equals blk_en) |
| byte_data | input | DATA_W | Received byte |
| cand_we | input | 1 | Candidate write strobe |
| cand_idx | input | IDX_W | Slot selected for the candidate write |
| cand_wdata | input | DATA_W | Candidate value |
| arm_we | input | 1 | Whole arm vector write strobe |
| arm_wdata | input | N_SLOTS | Arm vector value |
| once_we | input | 1 | Single-use vector write strobe |
| once_wdata | input | N_SLOTS | Single-use vector value |
| chain_we | input | 1 | Chain vector write strobe |
| chain_wdata | input | N_SLOTS | Chain vector value, bit i chains slot i to the next slot |
| task_arm | input | N_SLOTS | Per-slot arm strobes |
| task_disarm | input | N_SLOTS | Per-slot disarm strobes |
| evt_we | input | 1 | Event flag write strobe |
| evt_wdata | input | N_SLOTS | Event flag write value; a 0 bit clears that flag |
| irq_en | input | N_SLOTS | Per-slot interrupt enables |
| arm_state | output | N_SLOTS | Current arm bits |
| hit | output | N_SLOTS | One-cycle pulse per slot that fired |
| evt_flag | output | N_SLOTS | Sticky per-slot event flags |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take for granted that a strobe or write lasts one clock cycle. They also take for granted that a byte counts only on a cycle where valid and ready are both high, so the chaining and single-use checks look only one cycle ahead. The stimulus changes inputs only at the falling edge and draws byte values mostly from the programmed candidates, so that hits are frequent. It also raises arm and disarm strobes on the same slot together to exercise the priority rule. In some phases it drops `blk_en` while bytes are still offered.

// File: rtl/rxm_pkg.sv
package rxm_pkg;
  localparam int unsigned DEF_SLOTS  = 4;
  localparam int unsigned DEF_DATA_W = 8;

  // resolve one control bit: set wins over clear, clear wins over base
  function automatic logic resolve_bit(input logic set_i, input logic clr_i,
                                       input logic base_i);
    if (set_i)      return 1'b1;
    else if (clr_i) return 1'b0;
    else            return base_i;
  endfunction
endpackage

// File: rtl/rxm_slot.sv
module rxm_slot #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cand_we,
  input  logic [DATA_W-1:0] cand_wdata,
  input  logic              byte_fire,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              armed,
  output logic              match
);
  logic [DATA_W-1:0] cand_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cand_q <= '0;
    else if (cand_we) cand_q <= cand_wdata;
  end

  assign match = byte_fire && armed && (cand_q == byte_data);

  AST_MATCH_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> (byte_fire && armed)); // R1
endmodule

// File: rtl/rxm_arm_ctrl.sv
module rxm_arm_ctrl
  import rxm_pkg::*;
#(
  parameter int unsigned N_SLOTS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm_we,
  input  logic [N_SLOTS-1:0] arm_wdata,
  input  logic [N_SLOTS-1:0] task_arm,
  input  logic [N_SLOTS-1:0] task_disarm,
  input  logic [N_SLOTS-1:0] once,
  input  logic [N_SLOTS-1:0] chain,
  input  logic [N_SLOTS-1:0] match,
  output logic [N_SLOTS-1:0] arm_q
);
  logic [N_SLOTS-1:0] chain_in;
  logic [N_SLOTS-1:0] set_v, clr_v, base_v, arm_d;

  genvar gi;
  generate
    for (gi = 0; gi < N_SLOTS; gi++) begin : g_bit
      localparam int unsigned PREV = (gi + N_SLOTS - 1) % N_SLOTS;
      localparam int unsigned NEXT = (gi + 1) % N_SLOTS;
      assign chain_in[gi] = match[PREV] && chain[PREV];
      assign set_v[gi]    = task_arm[gi] || chain_in[gi];
      assign clr_v[gi]    = task_disarm[gi] || (match[gi] && once[gi]);
      assign base_v[gi]   = arm_we ? arm_wdata[gi] : arm_q[gi];
      assign arm_d[gi]    = resolve_bit(set_v[gi], clr_v[gi], base_v[gi]);

      AST_ONCE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (match[gi] && once[gi] && !task_arm[gi] && !chain_in[gi]) |=> !arm_q[gi]); // R2
      AST_DISARM_TASK: assert property (@(posedge clk) disable iff (!rst_n)
        (task_disarm[gi] && !task_arm[gi] && !chain_in[gi]) |=> !arm_q[gi]); // R3
      AST_ARM_TASK: assert property (@(posedge clk) disable iff (!rst_n)
        task_arm[gi] |=> arm_q[gi]); // R8
      AST_CHAIN_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (match[gi] && chain[gi]) |=> arm_q[NEXT]); // R4
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= '0;
    else        arm_q <= arm_d;
  end
endmodule

// File: rtl/rxm_event.sv
module rxm_event #(
  parameter int unsigned N_SLOTS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               blk_en,
  input  logic [N_SLOTS-1:0] match,
  input  logic               evt_we,
  input  logic [N_SLOTS-1:0] evt_wdata,
  input  logic [N_SLOTS-1:0] irq_en,
  output logic [N_SLOTS-1:0] evt_flag,
  output logic [N_SLOTS-1:0] hit,
  output logic               irq
);
  logic [N_SLOTS-1:0] keep_v;

  assign keep_v = evt_we ? (evt_flag & evt_wdata) : evt_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_flag <= '0;
      hit      <= '0;
    end else if (!blk_en) begin
      evt_flag <= '0;
      hit      <= '0;
    end else begin
      evt_flag <= match | keep_v;
      hit      <= match;
    end
  end

  assign irq = |(evt_flag & irq_en);

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_en && (match != '0)) |=> ((evt_flag & $past(match)) == $past(match))); // R5
  AST_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_en |=> (evt_flag == '0 && hit == '0)); // R9
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (match == '0) |=> ((evt_flag & ~$past(evt_flag)) == '0)); // R6
endmodule

// File: rtl/rxbyte_match.sv
module rxbyte_match
  import rxm_pkg::*;
#(
  parameter int unsigned N_SLOTS = DEF_SLOTS,
  parameter int unsigned DATA_W  = DEF_DATA_W,
  localparam int unsigned IDX_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               blk_en,
  input  logic               byte_valid,
  output logic               byte_ready,
  input  logic [DATA_W-1:0]  byte_data,
  input  logic               cand_we,
  input  logic [IDX_W-1:0]   cand_idx,
  input  logic [DATA_W-1:0]  cand_wdata,
  input  logic               arm_we,
  input  logic [N_SLOTS-1:0] arm_wdata,
  input  logic               once_we,
  input  logic [N_SLOTS-1:0] once_wdata,
  input  logic               chain_we,
  input  logic [N_SLOTS-1:0] chain_wdata,
  input  logic [N_SLOTS-1:0] task_arm,
  input  logic [N_SLOTS-1:0] task_disarm,
  input  logic               evt_we,
  input  logic [N_SLOTS-1:0] evt_wdata,
  input  logic [N_SLOTS-1:0] irq_en,
  output logic [N_SLOTS-1:0] arm_state,
  output logic [N_SLOTS-1:0] hit,
  output logic [N_SLOTS-1:0] evt_flag,
  output logic               irq
);
  logic               byte_fire;
  logic [N_SLOTS-1:0] match;
  logic [N_SLOTS-1:0] once_q, chain_q, arm_q;

  assign byte_ready = blk_en;
  assign byte_fire  = byte_valid && byte_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      once_q  <= '0;
      chain_q <= '0;
    end else begin
      if (once_we)  once_q  <= once_wdata;
      if (chain_we) chain_q <= chain_wdata;
    end
  end

  genvar gs;
  generate
    for (gs = 0; gs < N_SLOTS; gs++) begin : g_slot
      rxm_slot #(.DATA_W(DATA_W)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .cand_we    (cand_we && (cand_idx == IDX_W'(gs))),
        .cand_wdata (cand_wdata),
        .byte_fire  (byte_fire),
        .byte_data  (byte_data),
        .armed      (arm_q[gs]),
        .match      (match[gs])
      );
    end
  endgenerate

  rxm_arm_ctrl #(.N_SLOTS(N_SLOTS)) u_arm (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm_we      (arm_we),
    .arm_wdata   (arm_wdata),
    .task_arm    (task_arm),
    .task_disarm (task_disarm),
    .once        (once_q),
    .chain       (chain_q),
    .match       (match),
    .arm_q       (arm_q)
  );

  rxm_event #(.N_SLOTS(N_SLOTS)) u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .blk_en    (blk_en),
    .match     (match),
    .evt_we    (evt_we),
    .evt_wdata (evt_wdata),
    .irq_en    (irq_en),
    .evt_flag  (evt_flag),
    .hit       (hit),
    .irq       (irq)
  );

  assign arm_state = arm_q;

  AST_HIT_ON_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |-> $past(byte_valid && byte_ready)); // R6
  AST_HIT_WAS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |-> ((hit & ~$past(arm_q)) == '0)); // R1
endmodule

// File: tb/rxbyte_match_test.sv
`timescale 1ns/1ps
module rxbyte_match_test;
  localparam int N = 4;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic blk_en = 1'b0, byte_valid = 1'b0, cand_we = 1'b0, arm_we = 1'b0;
  logic once_we = 1'b0, chain_we = 1'b0, evt_we = 1'b0;
  logic [W-1:0] byte_data = '0, cand_wdata = '0;
  logic [1:0] cand_idx = '0;
  logic [N-1:0] arm_wdata = '0, once_wdata = '0, chain_wdata = '0;
  logic [N-1:0] task_arm = '0, task_disarm = '0, evt_wdata = '0, irq_en = '0;
  logic byte_ready, irq;
  logic [N-1:0] arm_state, hit, evt_flag;

  always #2.5 clk = ~clk;

  rxbyte_match uut (
    .clk(clk), .rst_n(rst_n), .blk_en(blk_en), .byte_valid(byte_valid),
    .byte_ready(byte_ready), .byte_data(byte_data), .cand_we(cand_we),
    .cand_idx(cand_idx), .cand_wdata(cand_wdata), .arm_we(arm_we),
    .arm_wdata(arm_wdata), .once_we(once_we), .once_wdata(once_wdata),
    .chain_we(chain_we), .chain_wdata(chain_wdata), .task_arm(task_arm),
    .task_disarm(task_disarm), .evt_we(evt_we), .evt_wdata(evt_wdata),
    .irq_en(irq_en), .arm_state(arm_state), .hit(hit), .evt_flag(evt_flag),
    .irq(irq)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // reference state
  logic [W-1:0] m_cand [N];
  logic [N-1:0] m_arm = '0, m_once = '0, m_chain = '0, m_flag = '0, m_hit = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [N-1:0] calc_match();
    logic [N-1:0] m;
    for (int i = 0; i < N; i++)
      m[i] = blk_en && byte_valid && m_arm[i] && (m_cand[i] == byte_data);
    return m;
  endfunction

  // advance reference with the inputs currently driven
  task automatic model_step();
    logic [N-1:0] m, na;
    m = calc_match();
    for (int i = 0; i < N; i++) begin
      int p;
      logic s, c, b;
      p = (i + N - 1) % N;
      s = task_arm[i] || (m[p] && m_chain[p]);
      c = task_disarm[i] || (m[i] && m_once[i]);
      b = arm_we ? arm_wdata[i] : m_arm[i];
      na[i] = s ? 1'b1 : (c ? 1'b0 : b);
    end
    if (!blk_en) begin
      m_flag = '0; m_hit = '0;
    end else begin
      m_flag = m | (evt_we ? (m_flag & evt_wdata) : m_flag);
      m_hit  = m;
    end
    m_arm = na;
    if (cand_we) m_cand[cand_idx] = cand_wdata;
    if (once_we) m_once = once_wdata;
    if (chain_we) m_chain = chain_wdata;
  endtask

  task automatic compare_all(input string ctx);
    chk({ctx, " R6 ready"}, 32'(byte_ready), 32'(blk_en));
    chk({ctx, " R2 R3 R4 R8 R10 arm"}, 32'(arm_state), 32'(m_arm));
    chk({ctx, " R1 R7 hit"}, 32'(hit), 32'(m_hit));
    chk({ctx, " R5 R9 flag"}, 32'(evt_flag), 32'(m_flag));
    chk({ctx, " R5 irq"}, 32'(irq), 32'(|(m_flag & irq_en)));
  endtask

  task automatic idle_inputs();
    byte_valid = 0; cand_we = 0; arm_we = 0; once_we = 0; chain_we = 0;
    evt_we = 0; task_arm = '0; task_disarm = '0;
  endtask

  // inputs already driven (after a negedge); clock them in and check
  task automatic step(input string ctx);
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all(ctx);
    idle_inputs();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) m_cand[i] = '0;
    repeat (3) @(negedge clk);
    compare_all("reset R10");
    rst_n = 1;
    @(negedge clk);
    compare_all("after reset R10");
    blk_en = 1;

    // program candidates 0x41..0x44
    for (int i = 0; i < N; i++) begin
      cand_we = 1; cand_idx = 2'(i); cand_wdata = 8'h41 + 8'(i);
      step("cand write R10");
    end
    // chain 0->1->2->3->0, arm slot 0 only
    chain_we = 1; chain_wdata = 4'b1111; arm_we = 1; arm_wdata = 4'b0001;
    step("chain setup R10");
    irq_en = 4'b1000;
    byte_valid = 1; byte_data = 8'h41; step("seq byte0 R4");
    byte_valid = 1; byte_data = 8'h42; step("seq byte1 R4");
    byte_valid = 1; byte_data = 8'h43; step("seq byte2 R4");
    byte_valid = 1; byte_data = 8'h44; step("seq byte3 wrap R4");
    chk("R4 wrap to slot0", 32'(arm_state[0]), 32'd1);
    chk("R5 irq from slot3", 32'(irq), 32'd1);
    // valid low: ignored
    byte_valid = 0; byte_data = 8'h41; step("valid low R6");
    chk("R6 no hit when valid low", 32'(hit), 32'd0);
    // clear flags by writing zero
    evt_we = 1; evt_wdata = 4'b0000; step("flag clear R9");
    chk("R9 flags cleared", 32'(evt_flag), 32'd0);
    // multi-slot match: all candidates equal 0x55
    for (int i = 0; i < N; i++) begin
      cand_we = 1; cand_idx = 2'(i); cand_wdata = 8'h55; step("cand eq R10");
    end
    chain_we = 1; chain_wdata = '0; once_we = 1; once_wdata = 4'b0101;
    arm_we = 1; arm_wdata = 4'b1111; step("multi setup R10");
    byte_valid = 1; byte_data = 8'h55; step("multi hit R7");
    chk("R7 all slots hit", 32'(hit), 32'hF);
    chk("R2 single-use slots disarmed", 32'(arm_state), 32'b1010);
    // set beats clear on same slot
    task_arm = 4'b0001; task_disarm = 4'b0011; step("priority R8");
    chk("R8 set wins", 32'(arm_state), 32'b1001);
    chk("R3 disarm only slot1", 32'(arm_state[3]), 32'd1);
    // single-use hit with concurrent arm task keeps slot armed
    byte_valid = 1; byte_data = 8'h55; task_arm = 4'b0001; step("once vs arm R8");
    chk("R8 arm beats single-use", 32'(arm_state[0]), 32'd1);
    // disabled: refuse bytes, flags zero
    blk_en = 0; byte_valid = 1; byte_data = 8'h55; step("disabled R9");
    chk("R9 flags held zero", 32'(evt_flag), 32'd0);
    chk("R6 ready low when disabled", 32'(byte_ready), 32'd0);
    blk_en = 1;

    // constrained random phase
    for (int n = 0; n < 3000; n++) begin
      if (($urandom % 50) == 0) begin
        cand_we = 1; cand_idx = 2'($urandom % N); cand_wdata = 8'h30 + 8'($urandom % 6);
      end
      if (($urandom % 40) == 0) begin arm_we = 1; arm_wdata = 4'($urandom); end
      if (($urandom % 60) == 0) begin once_we = 1; once_wdata = 4'($urandom); end
      if (($urandom % 60) == 0) begin chain_we = 1; chain_wdata = 4'($urandom); end
      if (($urandom % 8) == 0) task_arm = 4'($urandom);
      if (($urandom % 8) == 0) task_disarm = 4'($urandom);
      if (($urandom % 12) == 0) begin evt_we = 1; evt_wdata = 4'($urandom); end
      if (($urandom % 30) == 0) irq_en = 4'($urandom);
      if (($urandom % 100) == 0) blk_en = ~blk_en;
      byte_valid = ($urandom % 3) != 0;
      byte_data = 8'h30 + 8'($urandom % 7);
      step("random R1 R3 R8");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule